// File: doc/BRIEF.md
# Hashed Inverted Page Table Lookup

This block keeps an inverted translation table with exactly one slot per physical frame. Each slot records whether it is occupied, which process owns it, which virtual page sits in it, a protection code, and used and dirty flags. The frame number is never stored: the index of the slot that holds a mapping is the frame number.

A request carries a process ID and a virtual page number. The block hashes that pair to a starting slot and examines one slot per clock. When the slot holds the same key, the search ends with a hit. When the slot is empty, the search ends with a miss. In every other case the block steps to another slot and tries again. A lookup that hits returns the frame number and the protection code, then marks the slot as used (and as dirty for a write access). An insert follows the same probe order. It installs the mapping in the first empty slot it meets, or it returns the existing frame if the key is already present. A probe limit equal to the table size ends any search on a full table.

Top module: `hipt_lookup`

## Requirements
- R1: After reset every slot is empty, `busy` and `rsp_valid` are low, and a lookup misses after a single probe.
- R2: The first slot probed is the XOR fold of the key {pid, vpn}: key bit i is XORed into index bit (i mod IDX_W).
- R3: A lookup hits only on a slot that is resident and whose stored pid and vpn both equal the key. It then returns rsp_hit=1, rsp_frame equal to that slot index, and the stored protection code.
- R4: A resident slot that does not match makes the next probed slot (index + STEP) mod 2^IDX_W. A non-resident slot ends a lookup as a miss, with rsp_hit, rsp_frame, rsp_prot, rsp_used and rsp_dirty all 0.
- R5: A search stops after at most 2^IDX_W probes. If no match and no empty slot has been seen, it reports rsp_hit=0 and rsp_probes=2^IDX_W.
- R6: An insert writes pid, vpn and protection into the first non-resident probed slot, marks it resident with clear used and dirty flags, and returns rsp_hit=1 with that slot as rsp_frame.
- R7: An insert whose key is already resident changes nothing and returns rsp_hit=1 with the existing frame and its stored protection.
- R8: One slot is examined per clock. rsp_valid pulses for one cycle, exactly rsp_probes clocks after the clock edge that accepted the request, and `busy` is low in that cycle.
- R9: A request presented while `busy` is high is ignored.
- R10: A lookup hit reports the used and dirty flags as they were before the access, then sets used, and sets dirty when req_write=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_insert | input | 1 | 1 = insert, 0 = lookup |
| req_write | input | 1 | Lookup is a write access (sets dirty) |
| req_pid | input | PID_W | Process ID of the key |
| req_vpn | input | VPN_W | Virtual page number of the key |
| req_prot | input | PROT_W | Protection code for an insert |
| busy | output | 1 | A search is in progress |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_hit | output | 1 | Key resident after the operation |
| rsp_frame | output | IDX_W | Frame number (slot index) |
| rsp_prot | output | PROT_W | Protection code of the slot |
| rsp_used | output | 1 | Used flag before the access |
| rsp_dirty | output | 1 | Dirty flag before the access |
| rsp_probes | output | IDX_W+1 | Slots examined |

## Verification
The bench builds the block with its defaults: 64 slots, STEP=7, a 4-bit pid and a 12-bit vpn. The random phase draws keys from a small pid and vpn space, so chains of collisions several probes long form often, and inserts fill the slots along a probe chain. A 64-slot table is small enough to fill completely. That brings both the full-table insert failure and the 64-probe lookup miss within reach. The bench also injects requests while a search is busy and checks that they are ignored.

// File: rtl/hipt_pkg.sv
package hipt_pkg;
  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_PROBE = 1'b1
  } hipt_state_e;
endpackage

// File: rtl/hipt_hash.sv
module hipt_hash #(
  parameter int KEY_W = 16,
  parameter int IDX_W = 6,
  parameter int STEP  = 7
) (
  input  logic [KEY_W-1:0] key,
  input  logic [IDX_W-1:0] cur_idx,
  output logic [IDX_W-1:0] start_idx,
  output logic [IDX_W-1:0] next_idx
);
  always_comb begin
    start_idx = '0;
    for (int i = 0; i < KEY_W; i++) begin
      start_idx[i % IDX_W] = start_idx[i % IDX_W] ^ key[i];
    end
  end

  assign next_idx = cur_idx + IDX_W'(STEP);
endmodule

// File: rtl/hipt_table.sv
module hipt_table #(
  parameter int IDX_W  = 6,
  parameter int PID_W  = 4,
  parameter int VPN_W  = 12,
  parameter int PROT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_new,
  input  logic              touch_en,
  input  logic              touch_dirty,
  input  logic [PID_W-1:0]  wr_pid,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PROT_W-1:0] wr_prot,
  output logic              rd_res,
  output logic [PID_W-1:0]  rd_pid,
  output logic [VPN_W-1:0]  rd_vpn,
  output logic [PROT_W-1:0] rd_prot,
  output logic              rd_used,
  output logic              rd_dirty,
  output logic [(1<<IDX_W)-1:0] res_vec
);
  localparam int SLOTS = 1 << IDX_W;

  logic [SLOTS-1:0]  res_q;
  logic [SLOTS-1:0]  used_q;
  logic [SLOTS-1:0]  dirty_q;
  logic [PID_W-1:0]  pid_q  [SLOTS];
  logic [VPN_W-1:0]  vpn_q  [SLOTS];
  logic [PROT_W-1:0] prot_q [SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (wr_new) begin
      res_q[rd_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_new) begin
      pid_q[rd_idx]   <= wr_pid;
      vpn_q[rd_idx]   <= wr_vpn;
      prot_q[rd_idx]  <= wr_prot;
      used_q[rd_idx]  <= 1'b0;
      dirty_q[rd_idx] <= 1'b0;
    end else if (touch_en) begin
      used_q[rd_idx]  <= 1'b1;
      dirty_q[rd_idx] <= dirty_q[rd_idx] | touch_dirty;
    end
  end

  assign rd_res   = res_q[rd_idx];
  assign rd_pid   = pid_q[rd_idx];
  assign rd_vpn   = vpn_q[rd_idx];
  assign rd_prot  = prot_q[rd_idx];
  assign rd_used  = used_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign res_vec  = res_q;
endmodule

// File: rtl/hipt_ctrl.sv
module hipt_ctrl
  import hipt_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int PID_W  = 4,
  parameter int VPN_W  = 12,
  parameter int PROT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_insert,
  input  logic              req_write,
  input  logic [PID_W-1:0]  req_pid,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [PROT_W-1:0] req_prot,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [IDX_W-1:0]  next_idx,
  input  logic              rd_res,
  input  logic [PID_W-1:0]  rd_pid,
  input  logic [VPN_W-1:0]  rd_vpn,
  input  logic [PROT_W-1:0] rd_prot,
  input  logic              rd_used,
  input  logic              rd_dirty,
  output logic [IDX_W-1:0]  probe_idx,
  output logic [PID_W+VPN_W-1:0] key_cur,
  output logic [PROT_W-1:0] key_prot,
  output logic              wr_new,
  output logic              touch_en,
  output logic              touch_dirty,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_frame,
  output logic [PROT_W-1:0] rsp_prot,
  output logic              rsp_used,
  output logic              rsp_dirty,
  output logic [IDX_W:0]    rsp_probes
);
  localparam int SLOTS = 1 << IDX_W;
  localparam int CNT_W = IDX_W + 1;

  hipt_state_e       state_q, state_d;
  logic              ins_q, wrt_q;
  logic [PID_W-1:0]  pid_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [PROT_W-1:0] prot_q;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;

  logic probing, accept, match, empty, last, done, step_en, idx_en;
  logic              hit_d;
  logic [IDX_W-1:0]  frame_d;
  logic [PROT_W-1:0] prot_d;
  logic              used_d, dirty_d;

  always_comb begin
    probing = (state_q == ST_PROBE);
    accept  = (state_q == ST_IDLE) && req_valid;
    cnt_inc = cnt_q + CNT_W'(1);
    match   = rd_res && (rd_pid == pid_q) && (rd_vpn == vpn_q);
    empty   = !rd_res;
    last    = (cnt_inc == CNT_W'(SLOTS));
    done    = probing && (match || empty || last);
    step_en = probing && !done;
    idx_en  = accept || step_en;

    wr_new      = probing && ins_q && empty;
    touch_en    = probing && !ins_q && match;
    touch_dirty = wrt_q;

    hit_d   = match || (ins_q && empty);
    frame_d = hit_d ? idx_q : '0;
    prot_d  = match ? rd_prot : ((ins_q && empty) ? prot_q : '0);
    used_d  = match && rd_used;
    dirty_d = match && rd_dirty;

    idx_d   = accept ? start_idx : next_idx;
    cnt_d   = accept ? '0 : cnt_inc;

    state_d = state_q;
    if (accept)    state_d = ST_PROBE;
    else if (done) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rsp_valid <= 1'b0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_q  <= 1'b0;
      wrt_q  <= 1'b0;
      pid_q  <= '0;
      vpn_q  <= '0;
      prot_q <= '0;
    end else if (accept) begin
      ins_q  <= req_insert;
      wrt_q  <= req_write;
      pid_q  <= req_pid;
      vpn_q  <= req_vpn;
      prot_q <= req_prot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit    <= 1'b0;
      rsp_frame  <= '0;
      rsp_prot   <= '0;
      rsp_used   <= 1'b0;
      rsp_dirty  <= 1'b0;
      rsp_probes <= '0;
    end else if (done) begin
      rsp_hit    <= hit_d;
      rsp_frame  <= frame_d;
      rsp_prot   <= prot_d;
      rsp_used   <= used_d;
      rsp_dirty  <= dirty_d;
      rsp_probes <= cnt_inc;
    end
  end

  assign probe_idx = idx_q;
  assign key_cur   = {pid_q, vpn_q};
  assign key_prot  = prot_q;
  assign busy      = probing;
endmodule

// File: rtl/hipt_lookup.sv
module hipt_lookup #(
  parameter int IDX_W  = 6,
  parameter int PID_W  = 4,
  parameter int VPN_W  = 12,
  parameter int PROT_W = 3,
  parameter int STEP   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_insert,
  input  logic              req_write,
  input  logic [PID_W-1:0]  req_pid,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [PROT_W-1:0] req_prot,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_frame,
  output logic [PROT_W-1:0] rsp_prot,
  output logic              rsp_used,
  output logic              rsp_dirty,
  output logic [IDX_W:0]    rsp_probes
);
  localparam int KEY_W = PID_W + VPN_W;
  localparam int SLOTS = 1 << IDX_W;

  logic [IDX_W-1:0]  start_idx, next_idx, probe_idx;
  logic [KEY_W-1:0]  key_cur;
  logic [PROT_W-1:0] key_prot;
  logic              wr_new, touch_en, touch_dirty;
  logic              rd_res, rd_used, rd_dirty;
  logic [PID_W-1:0]  rd_pid;
  logic [VPN_W-1:0]  rd_vpn;
  logic [PROT_W-1:0] rd_prot;
  logic [SLOTS-1:0]  res_vec;

  hipt_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W), .STEP(STEP)) u_hash (
    .key       ({req_pid, req_vpn}),
    .cur_idx   (probe_idx),
    .start_idx (start_idx),
    .next_idx  (next_idx)
  );

  hipt_table #(.IDX_W(IDX_W), .PID_W(PID_W), .VPN_W(VPN_W), .PROT_W(PROT_W)) u_tab (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_idx      (probe_idx),
    .wr_new      (wr_new),
    .touch_en    (touch_en),
    .touch_dirty (touch_dirty),
    .wr_pid      (key_cur[KEY_W-1:VPN_W]),
    .wr_vpn      (key_cur[VPN_W-1:0]),
    .wr_prot     (key_prot),
    .rd_res      (rd_res),
    .rd_pid      (rd_pid),
    .rd_vpn      (rd_vpn),
    .rd_prot     (rd_prot),
    .rd_used     (rd_used),
    .rd_dirty    (rd_dirty),
    .res_vec     (res_vec)
  );

  hipt_ctrl #(.IDX_W(IDX_W), .PID_W(PID_W), .VPN_W(VPN_W), .PROT_W(PROT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_insert  (req_insert),
    .req_write   (req_write),
    .req_pid     (req_pid),
    .req_vpn     (req_vpn),
    .req_prot    (req_prot),
    .start_idx   (start_idx),
    .next_idx    (next_idx),
    .rd_res      (rd_res),
    .rd_pid      (rd_pid),
    .rd_vpn      (rd_vpn),
    .rd_prot     (rd_prot),
    .rd_used     (rd_used),
    .rd_dirty    (rd_dirty),
    .probe_idx   (probe_idx),
    .key_cur     (key_cur),
    .key_prot    (key_prot),
    .wr_new      (wr_new),
    .touch_en    (touch_en),
    .touch_dirty (touch_dirty),
    .busy        (busy),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_frame   (rsp_frame),
    .rsp_prot    (rsp_prot),
    .rsp_used    (rsp_used),
    .rsp_dirty   (rsp_dirty),
    .rsp_probes  (rsp_probes)
  );
endmodule

// File: rtl/hipt_lookup_chk.sv
module hipt_lookup_chk #(
  parameter int IDX_W = 6,
  parameter int KEY_W = 16,
  parameter int STEP  = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy,
  input logic                 rsp_valid,
  input logic                 rsp_hit,
  input logic [IDX_W-1:0]     rsp_frame,
  input logic [IDX_W:0]       rsp_probes,
  input logic [IDX_W-1:0]     probe_idx,
  input logic [KEY_W-1:0]     key_cur,
  input logic [(1<<IDX_W)-1:0] res_vec
);
  localparam int SLOTS = 1 << IDX_W;

  assert_rsp_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);

  assert_probe_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_probes != '0) && (rsp_probes <= (IDX_W+1)'(SLOTS)));

  assert_hit_resident_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> res_vec[rsp_frame]);

  assert_rehash_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (probe_idx == $past(probe_idx) + IDX_W'(STEP)));

  assert_key_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(key_cur));
endmodule

bind hipt_lookup hipt_lookup_chk #(
  .IDX_W (IDX_W),
  .KEY_W (PID_W + VPN_W),
  .STEP  (STEP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_frame  (rsp_frame),
  .rsp_probes (rsp_probes),
  .probe_idx  (probe_idx),
  .key_cur    (key_cur),
  .res_vec    (res_vec)
);

// File: tb/sim_hipt_lookup.sv
module sim_hipt_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W  = 6;
  localparam int PID_W  = 4;
  localparam int VPN_W  = 12;
  localparam int PROT_W = 3;
  localparam int STEP   = 7;
  localparam int SLOTS  = 64;

  logic clk, rst_n;
  logic req_valid, req_insert, req_write;
  logic [PID_W-1:0]  req_pid;
  logic [VPN_W-1:0]  req_vpn;
  logic [PROT_W-1:0] req_prot;
  logic busy, rsp_valid, rsp_hit, rsp_used, rsp_dirty;
  logic [IDX_W-1:0]  rsp_frame;
  logic [PROT_W-1:0] rsp_prot;
  logic [IDX_W:0]    rsp_probes;

  int n_chk, n_err;

  bit       m_res   [SLOTS];
  bit [3:0] m_pid   [SLOTS];
  bit [11:0] m_vpn  [SLOTS];
  bit [2:0] m_prot  [SLOTS];
  bit       m_used  [SLOTS];
  bit       m_dirty [SLOTS];

  hipt_lookup #(.IDX_W(IDX_W), .PID_W(PID_W), .VPN_W(VPN_W), .PROT_W(PROT_W), .STEP(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_insert(req_insert),
    .req_write(req_write), .req_pid(req_pid), .req_vpn(req_vpn), .req_prot(req_prot),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_frame(rsp_frame),
    .rsp_prot(rsp_prot), .rsp_used(rsp_used), .rsp_dirty(rsp_dirty), .rsp_probes(rsp_probes)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit [5:0] bhash(input bit [3:0] pid, input bit [11:0] vpn);
    bit [15:0] k;
    k = {pid, vpn};
    return k[5:0] ^ k[11:6] ^ {2'b00, k[15:12]};
  endfunction

  task automatic model_clear();
    for (int i = 0; i < SLOTS; i++) m_res[i] = 1'b0;
  endtask

  task automatic do_reset();
    req_valid = 0; req_insert = 0; req_write = 0;
    req_pid = '0; req_vpn = '0; req_prot = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_clear();
    @(negedge clk);
  endtask

  // noise: drive an unrelated insert request while busy (R9)
  task automatic do_req(input bit ins, input bit wr, input bit [3:0] pid,
                        input bit [11:0] vpn, input bit [2:0] prot, input bit noise,
                        input string tag);
    bit [5:0] idx;
    bit e_hit, e_used, e_dirty;
    bit [5:0] e_frame;
    bit [2:0] e_prot;
    int e_probes, cyc;
    idx = bhash(pid, vpn);
    e_hit = 0; e_frame = 0; e_prot = 0; e_used = 0; e_dirty = 0; e_probes = SLOTS;
    for (int n = 1; n <= SLOTS; n++) begin
      if (m_res[idx] && m_pid[idx] == pid && m_vpn[idx] == vpn) begin
        e_hit = 1; e_frame = idx; e_prot = m_prot[idx];
        e_used = m_used[idx]; e_dirty = m_dirty[idx]; e_probes = n;
        if (!ins) begin m_used[idx] = 1; m_dirty[idx] = m_dirty[idx] | wr; end
        break;
      end else if (!m_res[idx]) begin
        e_probes = n;
        if (ins) begin
          e_hit = 1; e_frame = idx; e_prot = prot;
          m_res[idx] = 1; m_pid[idx] = pid; m_vpn[idx] = vpn;
          m_prot[idx] = prot; m_used[idx] = 0; m_dirty[idx] = 0;
        end
        break;
      end
      idx = idx + 6'(STEP);
    end
    req_valid = 1; req_insert = ins; req_write = wr;
    req_pid = pid; req_vpn = vpn; req_prot = prot;
    @(negedge clk);
    req_valid = 0;
    cyc = 1;
    while (!rsp_valid && cyc < 200) begin
      if (noise) begin
        req_valid = 1; req_insert = 1; req_pid = 4'hF; req_vpn = 12'hFFF; req_prot = 3'd7;
      end
      @(negedge clk);
      req_valid = 0;
      cyc++;
    end
    chk(rsp_valid == 1, {tag, " R8 response seen"}, rsp_valid, 1);
    chk(cyc == e_probes + 1, {tag, " R8 latency"}, cyc - 1, e_probes);
    chk(int'(rsp_probes) == e_probes, {tag, " R4 probes"}, rsp_probes, e_probes);
    chk(rsp_hit == e_hit, {tag, " R3 hit"}, rsp_hit, e_hit);
    chk(rsp_frame == e_frame, {tag, " R3 frame"}, rsp_frame, e_frame);
    chk(rsp_prot == e_prot, {tag, " R3 prot"}, rsp_prot, e_prot);
    chk(rsp_used == e_used && rsp_dirty == e_dirty, {tag, " R10 flags"},
        {rsp_used, rsp_dirty}, {e_used, e_dirty});
    @(negedge clk);
    chk(rsp_valid == 0, {tag, " R8 single pulse"}, rsp_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++; n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    n_chk = 0; n_err = 0;
    do_reset();
    chk(busy == 0, "R1 busy after reset", busy, 0);
    chk(rsp_valid == 0, "R1 rsp_valid after reset", rsp_valid, 0);
    do_req(0, 0, 4'h0, 12'h000, 0, 0, "R1 empty lookup");
    chk(rsp_probes == 1 && rsp_hit == 0, "R1 single-probe miss", rsp_probes, 1);
    do_req(1, 0, 4'h0, 12'h000, 3'd5, 0, "R6 insert");
    chk(rsp_frame == 0, "R2 start slot of key 0", rsp_frame, 0);
    do_req(1, 0, 4'h1, 12'h001, 3'd3, 0, "R4 colliding insert");
    chk(rsp_frame == 7, "R4 rehash slot", rsp_frame, 7);
    do_req(0, 0, 4'h1, 12'h001, 0, 0, "R3 chained lookup");
    do_req(0, 0, 4'h0, 12'h041, 0, 0, "R4 miss after chain");
    chk(rsp_probes == 3, "R4 chain miss probes", rsp_probes, 3);
    do_req(0, 1, 4'h0, 12'h000, 0, 0, "R10 write lookup");
    do_req(0, 0, 4'h0, 12'h000, 0, 0, "R10 flags set");
    chk(rsp_used && rsp_dirty, "R10 used and dirty", {rsp_used, rsp_dirty}, 3);
    do_req(1, 0, 4'h0, 12'h000, 3'd1, 0, "R7 duplicate insert");
    chk(rsp_prot == 5, "R7 prot kept", rsp_prot, 5);
    do_req(0, 0, 4'h1, 12'h001, 0, 1, "R9 lookup under noise");
    do_req(0, 0, 4'hF, 12'hFFF, 0, 0, "R9 noise key absent");
    chk(rsp_hit == 0, "R9 noise ignored", rsp_hit, 0);

    for (int t = 0; t < 200; t++) begin
      bit ins, wr;
      bit [3:0] p;
      bit [11:0] v;
      ins = ($urandom % 3) == 0;
      wr  = $urandom % 2;
      p   = 4'($urandom % 4);
      v   = 12'($urandom % 16);
      do_req(ins, wr, p, v, 3'($urandom), ($urandom % 4) == 0, "R2 random");
    end

    do_reset();
    for (int i = 0; i < SLOTS; i++) begin
      do_req(1, 0, 4'h2, 12'(i * 3), 3'(i), 0, "R6 fill");
    end
    do_req(1, 0, 4'h9, 12'h777, 3'd2, 0, "R5 full insert");
    chk(rsp_hit == 0 && rsp_probes == 64, "R5 insert fails at limit", rsp_probes, 64);
    do_req(0, 0, 4'h9, 12'h778, 0, 0, "R5 full lookup");
    chk(rsp_hit == 0 && rsp_probes == 64, "R5 lookup limit", rsp_probes, 64);
    do_req(0, 0, 4'h2, 12'(63 * 3), 0, 0, "R3 lookup in full table");

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule